// File: doc/BRIEF.md
# Two-Phase Shared Register and Code Store

This block is the register file and program memory of a small processing core, held together in one two-port synchronous RAM and driven by a two-clock sequencer. Every instruction makes four RAM accesses: two operand reads, one instruction fetch and one result write. These are split over two phases. In the operand phase both ports read at once. In the writeback phase one port fetches the following instruction while the other stores the result. Because the RAM has one cycle of read latency, each address is presented one phase before its data is used.

A window of eight addresses near the top of the map is served by flip-flop registers and not by RAM. Two of them sample input pins and ignore writes. The other six are writable output and direction registers, and they drive the block's outputs. The program counter is a separate flip-flop register. A four-operation ALU and a jump let a loaded program exercise the data paths. While `run` is low, the program and data are loaded through the write port.

Top module: `dpreg_core`

## Requirements
- R1: While reset is asserted, and after it is released with `run` low, `pc_o` is 0, `phase_o` is 0 (fetch-only), and all six writable overlay registers read 0 on `io_regs_q`.
- R2: After `run` rises there is one fetch-only clock. From then on `phase_o` alternates between 1 (operand) and 2 (writeback), so each instruction takes exactly two clocks. Counting the first rising edge with `run` high as edge 0, the result of the i-th instruction (0-based) appears after edge 2i+2 and is absent before it.
- R3: In the operand phase both ports read in the same clock, one at the source address and one at the destination address, and nothing is written. A two-operand instruction therefore sees both values.
- R4: In the writeback phase the result is written to the destination only when write flag bit 27 of the instruction is 1. With the flag at 0 the destination keeps its value.
- R5: Instruction word layout: opcode in bits 31:28, write flag in bit 27, destination address in bits 17:9, source address in bits 8:0. The opcodes are 0 = move (dst := src), 1 = add (dst := dst + src), 2 = and, 3 = xor, and 4 = jump to the source field, which writes nothing. Any other opcode writes nothing.
- R6: Addresses 0x1F8 and 0x1F9 read the values sampled from `pins_in` bits 31:0 and 63:32 and ignore writes. Addresses 0x1FA to 0x1FF are writable flip-flops, and address 0x1FA+k appears on `io_regs_q[32k+31:32k]`. Operand reads of 0x1F8 to 0x1FF return the flip-flop value.
- R7: A program write to an overlay address changes only the flip-flop. The RAM word at that address keeps its value, and an instruction fetch from it returns the RAM word.
- R8: If the writeback writes the word that the fetch port reads in the same clock, the fetch returns the old word. The new word is seen the next time that address is fetched.
- R9: `pc_o` changes only at the end of a writeback phase. It becomes pc+1, or the source field for a jump.
- R10: While `run` is low in the fetch-only state, a high `ld_en` writes `ld_data` into the RAM word at `ld_addr`, including words under the overlay window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start execution from address 0 |
| ld_en | input | 1 | Load write strobe, honoured while not running |
| ld_addr | input | 9 | Load word address |
| ld_data | input | 32 | Load word data |
| pins_in | input | 64 | Input pin values for the two input overlay registers |
| io_regs_q | output | 192 | Six writable overlay registers, lowest address in the low bits |
| pc_o | output | 9 | Program counter |
| phase_o | output | 2 | Sequencer phase: 0 fetch-only, 1 operand, 2 writeback |

## Verification
The bench uses the default parameters: 32-bit words, 9-bit addresses, the overlay window at 0x1F8 with two input registers, and fetch-returns-old-data on a port collision. With these values the window sits at the top of a 512-word map, so a program can jump into the overlay range and fetch the RAM words hidden behind the flip-flops. The read-first collision setting is what lets the self-modifying test tell the old fetched word from the new one. With one instruction needing two clocks, edge-exact samples fall within a few clocks of start.

// File: rtl/dpreg_pkg.sv
package dpreg_pkg;

   typedef enum logic [1:0] {
      PH_FETCH = 2'd0,
      PH_OPER  = 2'd1,
      PH_WBACK = 2'd2
   } phase_e;

   typedef enum logic [3:0] {
      OP_MOV = 4'd0,
      OP_ADD = 4'd1,
      OP_AND = 4'd2,
      OP_XOR = 4'd3,
      OP_JMP = 4'd4
   } op_e;

endpackage

// File: rtl/dpreg_ram2p.sv
module dpreg_ram2p #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 9,
   parameter bit FETCH_OLD = 1'b1
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] a_addr,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] a_q;
   logic [DATA_W-1:0] b_q;

   // port B: the only writer
   always_ff @(posedge clk) begin
      if (b_we) begin
         mem[b_addr] <= b_wdata;
      end
      b_q <= mem[b_addr];
   end

   // port A: read-only, collision behaviour chosen by parameter
   generate
      if (FETCH_OLD) begin : g_rd_old
         always_ff @(posedge clk) begin
            a_q <= mem[a_addr];
         end
      end else begin : g_rd_new
         always_ff @(posedge clk) begin
            a_q <= (b_we && (b_addr == a_addr)) ? b_wdata : mem[a_addr];
         end
      end
   endgenerate

   assign a_rdata = a_q;
   assign b_rdata = b_q;
endmodule

// File: rtl/dpreg_overlay.sv
module dpreg_overlay #(
   parameter int DATA_W = 32,
   parameter int NUM    = 8,
   parameter int NUM_IN = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_IN*DATA_W-1:0]     pins_in,
   input  logic                         wr_en,
   input  logic [$clog2(NUM)-1:0]       wr_idx,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [$clog2(NUM)-1:0]       rd_idx_a,
   input  logic [$clog2(NUM)-1:0]       rd_idx_b,
   output logic [DATA_W-1:0]            rd_a,
   output logic [DATA_W-1:0]            rd_b,
   output logic [(NUM-NUM_IN)*DATA_W-1:0] regs_q
);
   logic [DATA_W-1:0] r [NUM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM; i++) begin
            r[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NUM; i++) begin
            if (i < NUM_IN) begin
               r[i] <= pins_in[i*DATA_W +: DATA_W];
            end else if (wr_en && (int'(wr_idx) == i)) begin
               r[i] <= wr_data;
            end
         end
      end
   end

   assign rd_a = r[rd_idx_a];
   assign rd_b = r[rd_idx_b];

   generate
      for (genvar j = NUM_IN; j < NUM; j++) begin : g_out
         assign regs_q[(j-NUM_IN)*DATA_W +: DATA_W] = r[j];
      end
   endgenerate
endmodule

// File: rtl/dpreg_alu.sv
module dpreg_alu
   import dpreg_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] src_val,
   output logic [DATA_W-1:0] res,
   output logic              wr_ok
);
   always_comb begin
      res   = dst_val;
      wr_ok = 1'b1;
      case (op)
         OP_MOV:  res = src_val;
         OP_ADD:  res = dst_val + src_val;
         OP_AND:  res = dst_val & src_val;
         OP_XOR:  res = dst_val ^ src_val;
         default: wr_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/dpreg_core.sv
module dpreg_core
   import dpreg_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 9,
   parameter int OVL_BASE  = 504,
   parameter int OVL_NUM   = 8,
   parameter int OVL_IN    = 2,
   parameter bit FETCH_OLD = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              run,
   input  logic                              ld_en,
   input  logic [ADDR_W-1:0]                 ld_addr,
   input  logic [DATA_W-1:0]                 ld_data,
   input  logic [OVL_IN*DATA_W-1:0]          pins_in,
   output logic [(OVL_NUM-OVL_IN)*DATA_W-1:0] io_regs_q,
   output logic [ADDR_W-1:0]                 pc_o,
   output logic [1:0]                        phase_o
);
   localparam int IDX_W  = $clog2(OVL_NUM);
   localparam int OP_MSB = DATA_W - 1;
   localparam int WR_BIT = DATA_W - 5;

   // elaboration-time parameter checks
   generate
      if (DATA_W < 2*ADDR_W + 5) begin : g_bad_width
         $error("dpreg_core: DATA_W too small for the instruction fields");
      end
      if (OVL_BASE + OVL_NUM > (1 << ADDR_W)) begin : g_bad_window
         $error("dpreg_core: overlay window exceeds the address space");
      end
      if ((OVL_IN < 1) || (OVL_IN >= OVL_NUM)) begin : g_bad_in
         $error("dpreg_core: OVL_IN must be between 1 and OVL_NUM-1");
      end
      if ((1 << IDX_W) != OVL_NUM) begin : g_bad_num
         $error("dpreg_core: OVL_NUM must be a power of two");
      end
   endgenerate

   function automatic logic in_ovl(input logic [ADDR_W-1:0] a);
      return ({1'b0, a} >= (ADDR_W+1)'(OVL_BASE)) &&
             ({1'b0, a} <  (ADDR_W+1)'(OVL_BASE + OVL_NUM));
   endfunction

   phase_e            phase_q, phase_d;
   logic [ADDR_W-1:0] pc_q, next_pc;
   op_e               op_q;
   logic              wr_q;
   logic [ADDR_W-1:0] src_q, dst_q;

   logic [ADDR_W-1:0] a_addr, b_addr;
   logic [DATA_W-1:0] a_rdata, b_rdata, b_wdata;
   logic              b_we;

   logic [ADDR_W-1:0] f_src, f_dst;
   logic              src_ovl, dst_ovl;
   logic [IDX_W-1:0]  src_idx, dst_idx;
   logic [DATA_W-1:0] ovl_rd_src, ovl_rd_dst;
   logic [DATA_W-1:0] src_val, dst_val, alu_res;
   logic              alu_wr, do_wr, prog_we, ovl_we;

   // fields of the word the fetch port just returned
   assign f_src = a_rdata[ADDR_W-1:0];
   assign f_dst = a_rdata[2*ADDR_W-1:ADDR_W];

   assign src_ovl = in_ovl(src_q);
   assign dst_ovl = in_ovl(dst_q);
   assign src_idx = IDX_W'(src_q - ADDR_W'(OVL_BASE));
   assign dst_idx = IDX_W'(dst_q - ADDR_W'(OVL_BASE));

   assign src_val = src_ovl ? ovl_rd_src : a_rdata;
   assign dst_val = dst_ovl ? ovl_rd_dst : b_rdata;

   assign do_wr   = (phase_q == PH_WBACK) && wr_q && alu_wr;
   assign prog_we = do_wr && !dst_ovl;
   assign ovl_we  = do_wr && dst_ovl;
   assign next_pc = (op_q == OP_JMP) ? src_q : pc_q + 1'b1;

   // port steering: addresses are set one phase before their data is used
   always_comb begin
      a_addr  = pc_q;
      b_addr  = ld_addr;
      b_wdata = ld_data;
      b_we    = 1'b0;
      case (phase_q)
         PH_FETCH: b_we = ld_en && !run;
         PH_OPER: begin
            a_addr = f_src;
            b_addr = f_dst;
         end
         PH_WBACK: begin
            a_addr  = next_pc;
            b_addr  = dst_q;
            b_wdata = alu_res;
            b_we    = prog_we;
         end
         default: ;
      endcase
   end

   always_comb begin
      case (phase_q)
         PH_FETCH: phase_d = run ? PH_OPER : PH_FETCH;
         PH_OPER:  phase_d = PH_WBACK;
         PH_WBACK: phase_d = PH_OPER;
         default:  phase_d = PH_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FETCH;
         pc_q    <= '0;
         op_q    <= OP_MOV;
         wr_q    <= 1'b0;
         src_q   <= '0;
         dst_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_OPER) begin
            op_q  <= op_e'(a_rdata[OP_MSB -: 4]);
            wr_q  <= a_rdata[WR_BIT];
            src_q <= f_src;
            dst_q <= f_dst;
         end
         if (phase_q == PH_WBACK) begin
            pc_q <= next_pc;
         end
      end
   end

   dpreg_ram2p #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .FETCH_OLD (FETCH_OLD)
   ) ram_i (
      .clk     (clk),
      .a_addr  (a_addr),
      .a_rdata (a_rdata),
      .b_we    (b_we),
      .b_addr  (b_addr),
      .b_wdata (b_wdata),
      .b_rdata (b_rdata)
   );

   dpreg_overlay #(
      .DATA_W (DATA_W),
      .NUM    (OVL_NUM),
      .NUM_IN (OVL_IN)
   ) ovl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_in  (pins_in),
      .wr_en    (ovl_we),
      .wr_idx   (dst_idx),
      .wr_data  (alu_res),
      .rd_idx_a (src_idx),
      .rd_idx_b (dst_idx),
      .rd_a     (ovl_rd_src),
      .rd_b     (ovl_rd_dst),
      .regs_q   (io_regs_q)
   );

   dpreg_alu #(
      .DATA_W (DATA_W)
   ) alu_i (
      .op      (op_q),
      .dst_val (dst_val),
      .src_val (src_val),
      .res     (alu_res),
      .wr_ok   (alu_wr)
   );

   assign pc_o    = pc_q;
   assign phase_o = phase_q;
endmodule

// File: rtl/dpreg_core_chk.sv
module dpreg_core_chk
   import dpreg_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int OVL_BASE = 504,
   parameter int OVL_NUM  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        phase,
   input logic [ADDR_W-1:0] pc,
   input logic              prog_we,
   input logic [ADDR_W-1:0] waddr,
   input logic              ram_we
);
   // R2
   oper_then_wback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'(PH_OPER)) |=> (phase == 2'(PH_WBACK)));

   // R2
   wback_then_oper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'(PH_WBACK)) |=> (phase == 2'(PH_OPER)));

   // R3
   oper_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'(PH_OPER)) |-> !ram_we);

   // R4
   prog_write_in_wback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_we |-> (phase == 2'(PH_WBACK)));

   // R7
   prog_write_not_overlay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_we |-> (({1'b0, waddr} < (ADDR_W+1)'(OVL_BASE)) ||
                   ({1'b0, waddr} >= (ADDR_W+1)'(OVL_BASE + OVL_NUM))));

   // R9
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != 2'(PH_WBACK)) |=> $stable(pc));
endmodule

bind dpreg_core dpreg_core_chk #(
   .ADDR_W   (ADDR_W),
   .OVL_BASE (OVL_BASE),
   .OVL_NUM  (OVL_NUM)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .phase   (phase_q),
   .pc      (pc_q),
   .prog_we (prog_we),
   .waddr   (b_addr),
   .ram_we  (b_we)
);

// File: tb/dpreg_core_tb.sv
`timescale 1ns/1ps
module dpreg_core_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run = 1'b0;
   logic         ld_en = 1'b0;
   logic [8:0]   ld_addr = '0;
   logic [31:0]  ld_data = '0;
   logic [63:0]  pins_in = '0;
   logic [191:0] io_regs_q;
   logic [8:0]   pc_o;
   logic [1:0]   phase_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   dpreg_core dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .ld_en     (ld_en),
      .ld_addr   (ld_addr),
      .ld_data   (ld_data),
      .pins_in   (pins_in),
      .io_regs_q (io_regs_q),
      .pc_o      (pc_o),
      .phase_o   (phase_o)
   );

   localparam logic [3:0] MOV = 4'd0, ADD = 4'd1, AND_ = 4'd2, XOR_ = 4'd3, JMP = 4'd4;

   function automatic logic [31:0] enc(logic [3:0] op, logic wr, logic [8:0] dst, logic [8:0] src);
      return {op, wr, 9'd0, dst, src};
   endfunction

   function automatic logic [31:0] ioreg(int a);
      return io_regs_q[(a - 'h1FA)*32 +: 32];
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      run   = 1'b0;
      ld_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic load(logic [8:0] a, logic [31:0] d);
      @(negedge clk);
      ld_en   = 1'b1;
      ld_addr = a;
      ld_data = d;
      @(negedge clk);
      ld_en   = 1'b0;
   endtask

   task automatic start();
      @(negedge clk);
      run = 1'b1;
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // R1: reset state
   task automatic t_reset();
      do_reset();
      check(pc_o == 9'd0, "R1", "pc after reset", 32'(pc_o), 32'd0);
      check(phase_o == 2'd0, "R1", "phase after reset", 32'(phase_o), 32'd0);
      check(io_regs_q == '0, "R1", "overlay regs after reset", io_regs_q[31:0], 32'd0);
   endtask

   // R2 R3 R4 R5 R9 R10: arithmetic program and its timing
   task automatic t_alu();
      logic [31:0] va = 32'h0000_00F0;
      logic [31:0] vb = 32'h1234_5678;
      logic [31:0] vc = 32'h0F0F_0F0F;
      do_reset();
      load(9'h100, va);
      load(9'h101, vb);
      load(9'h102, vc);
      load(9'd0, enc(MOV,  1'b1, 9'h1FA, 9'h100));
      load(9'd1, enc(ADD,  1'b1, 9'h100, 9'h101));
      load(9'd2, enc(MOV,  1'b1, 9'h1FB, 9'h100));
      load(9'd3, enc(AND_, 1'b1, 9'h101, 9'h102));
      load(9'd4, enc(MOV,  1'b1, 9'h1FC, 9'h101));
      load(9'd5, enc(XOR_, 1'b1, 9'h1FD, 9'h102));
      load(9'd6, enc(ADD,  1'b0, 9'h1FE, 9'h100));
      load(9'd7, enc(JMP,  1'b0, 9'd0,   9'd7));
      start();
      step(1);
      check(phase_o == 2'd1, "R2", "phase after fetch-only clock", 32'(phase_o), 32'd1);
      step(1);
      check(ioreg('h1FA) == 32'd0, "R2", "instr0 result too early", ioreg('h1FA), 32'd0);
      check(pc_o == 9'd0, "R9", "pc before first writeback", 32'(pc_o), 32'd0);
      step(1);
      check(ioreg('h1FA) == va, "R2", "instr0 result after edge 2", ioreg('h1FA), va);
      check(pc_o == 9'd1, "R9", "pc after first writeback", 32'(pc_o), 32'd1);
      check(phase_o == 2'd1, "R2", "phase back to operand", 32'(phase_o), 32'd1);
      step(3);
      check(ioreg('h1FB) == 32'd0, "R2", "instr2 result too early", ioreg('h1FB), 32'd0);
      step(1);
      check(ioreg('h1FB) == va + vb, "R3", "add of both operands", ioreg('h1FB), va + vb);
      step(30);
      check(ioreg('h1FC) == (vb & vc), "R5", "and result", ioreg('h1FC), vb & vc);
      check(ioreg('h1FD) == vc, "R5", "xor into overlay", ioreg('h1FD), vc);
      check(ioreg('h1FE) == 32'd0, "R4", "write flag clear keeps dst", ioreg('h1FE), 32'd0);
      check(pc_o == 9'd7, "R9", "jump to self", 32'(pc_o), 32'd7);
      check(ioreg('h1FA) == va, "R10", "loaded data used", ioreg('h1FA), va);
   endtask

   // R6: input overlay registers
   task automatic t_inputs();
      logic [31:0] x0 = 32'hA5A5_0001;
      logic [31:0] x1 = 32'h5A5A_0002;
      do_reset();
      pins_in = {x1, x0};
      load(9'h100, 32'hDEAD_BEEF);
      load(9'd0, enc(MOV, 1'b1, 9'h1FA, 9'h1F8));
      load(9'd1, enc(MOV, 1'b1, 9'h1F8, 9'h100));
      load(9'd2, enc(MOV, 1'b1, 9'h1FB, 9'h1F8));
      load(9'd3, enc(MOV, 1'b1, 9'h1FC, 9'h1F9));
      load(9'd4, enc(JMP, 1'b0, 9'd0,   9'd4));
      start();
      step(20);
      check(ioreg('h1FA) == x0, "R6", "read of input 0", ioreg('h1FA), x0);
      check(ioreg('h1FB) == x0, "R6", "input ignores write", ioreg('h1FB), x0);
      check(ioreg('h1FC) == x1, "R6", "read of input 1", ioreg('h1FC), x1);
   endtask

   // R7: overlay write leaves the RAM word, which is then fetched
   task automatic t_shadow();
      logic [31:0] c2 = 32'h7777_0001;
      logic [31:0] dv = 32'h3333_0002;
      do_reset();
      load(9'h120, c2);
      load(9'h121, dv);
      load(9'h1FA, enc(MOV, 1'b1, 9'h1FB, 9'h120));
      load(9'h1FB, enc(JMP, 1'b0, 9'd0,   9'h1FB));
      load(9'd0, enc(MOV, 1'b1, 9'h1FA, 9'h121));
      load(9'd1, enc(JMP, 1'b0, 9'd0,   9'h1FA));
      start();
      step(30);
      check(ioreg('h1FA) == dv, "R7", "overlay flop written", ioreg('h1FA), dv);
      check(ioreg('h1FB) == c2, "R7", "hidden RAM word executed", ioreg('h1FB), c2);
      check(pc_o == 9'h1FB, "R7", "hidden RAM jump loop", 32'(pc_o), 32'h1FB);
   endtask

   // R8: write and fetch of the same word in one clock
   task automatic t_collide();
      logic [31:0] v1 = 32'h1111_1111;
      logic [31:0] v2 = 32'h2222_2222;
      do_reset();
      load(9'h110, enc(MOV, 1'b1, 9'h1FA, 9'h112));
      load(9'h111, v1);
      load(9'h112, v2);
      load(9'd0, enc(MOV, 1'b1, 9'd1,   9'h110));
      load(9'd1, enc(MOV, 1'b1, 9'h1FA, 9'h111));
      load(9'd2, enc(JMP, 1'b0, 9'd0,   9'd1));
      start();
      step(5);
      check(ioreg('h1FA) == v1, "R8", "same-clock fetch returns old word", ioreg('h1FA), v1);
      step(10);
      check(ioreg('h1FA) == v2, "R8", "later fetch returns new word", ioreg('h1FA), v2);
   endtask

   initial begin
      t_reset();
      t_alu();
      t_inputs();
      t_shadow();
      t_collide();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule